// File: doc/BRIEF.md
# UART FIFO Control and DMA Request

This block holds the receive and transmit byte queues of a UART and derives from them the interrupt trigger flag and the two DMA request lines. Software configures it through one write-only control byte that switches the queues on or off, empties either queue on demand, turns on DMA handshaking and picks how many received bytes count as enough to ask for service.

The receive shifter pushes bytes into the RX queue and the bus pops them. The bus pushes bytes into the TX queue and the transmit shifter pops them. An external timer reports a character time-out. The RX request rises when enough bytes are waiting or when that time-out arrives. The TX request rises when the TX queue stops being full. Each request stays high until the DMA controller acknowledges it.

Top module: `uart_fifo_dma_ctrl`

## Requirements
- R1: After reset the control state is all zeros: queues disabled, DMA mode off, trigger code 0; both counts are 0, both requests and the overrun flag are low, and both pop data outputs are 0.
- R2: Control bit 0 is the queue enable, shown on `fifo_en` one clock after the write. Any write that changes it, in either direction, empties both queues at that edge. While it is clear, push and pop strobes have no effect.
- R3: Control bits 7:1 are captured only by a write whose bit 0 is 1; bits 5:4 are never used.
- R4: A write with bit 0 and bit 1 set empties the RX queue and clears the overrun flag; bit 0 with bit 2 set empties the TX queue. Neither bit is stored, so a later write without it empties nothing. An emptying write wins over a push or pop in the same cycle.
- R5: Each queue holds DEPTH bytes in arrival order. A push into a full queue with no pop that cycle is dropped; a push and a pop together on a full queue are both accepted. Counts, full and empty follow each edge.
- R6: A dropped RX push sets `rx_overrun`, which stays set until an RX emptying write or reset.
- R7: The popped byte appears on the pop data output one clock after the pop; a pop from an empty queue leaves that output and the queue unchanged.
- R8: `rx_level_hit` is high whenever the RX count is at least the level picked by control bits 7:6: code 0 is 1 byte, 1 is 4, 2 is 8, 3 is 14.
- R9: With enable and DMA mode (bit 3) set, `rx_dma_req` rises one clock after a cycle that saw `rx_level_hit` or `char_timeout` high, and stays high until `rx_dma_ack`; an acknowledge clears it at that edge even if a raise condition is present.
- R10: With enable and DMA mode set, `tx_dma_req` rises one clock after the first cycle in which the TX queue is not full following a full cycle, and stays high until `tx_dma_ack`, which wins the same way.
- R11: While enable or DMA mode is clear both requests are held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Control byte write strobe |
| cfg_wr_data | input | 8 | Control byte |
| rx_push | input | 1 | Receive shifter push strobe |
| rx_push_data | input | DATA_W | Received byte |
| rx_pop | input | 1 | Bus read of the RX queue |
| rx_pop_data | output | DATA_W | Last byte popped from the RX queue |
| tx_push | input | 1 | Bus write into the TX queue |
| tx_push_data | input | DATA_W | Byte to send |
| tx_pop | input | 1 | Transmit shifter pop strobe |
| tx_pop_data | output | DATA_W | Last byte popped from the TX queue |
| char_timeout | input | 1 | Character time-out from the external timer |
| rx_dma_ack | input | 1 | DMA controller clears the RX request |
| tx_dma_ack | input | 1 | DMA controller clears the TX request |
| fifo_en | output | 1 | Queue enable state |
| rx_count | output | CNT_W | Bytes in the RX queue |
| rx_empty | output | 1 | RX queue empty |
| rx_full | output | 1 | RX queue full |
| tx_count | output | CNT_W | Bytes in the TX queue |
| tx_empty | output | 1 | TX queue empty |
| tx_full | output | 1 | TX queue full |
| rx_overrun | output | 1 | Sticky RX drop flag |
| rx_level_hit | output | 1 | RX count reached the trigger level |
| rx_dma_req | output | 1 | RX DMA request |
| tx_dma_req | output | 1 | TX DMA request |

## Verification
The bench builds the block with its defaults, DATA_W of 8 and DEPTH of 16. Sixteen entries put all four trigger levels within reach, including 14, which sits two below full. The same depth lets the bench fill both queues within a few dozen cycles, so the drop at full, the simultaneous push and pop at full and the full to not-full TX raise are all exercised. A behavioural queue model is compared with every output on each clock, and directed checks mark the boundary counts of each level.

// File: rtl/ufd_pkg.sv
// Package: shared control byte layout and trigger level decode.
// Assumes the control byte is 8 bits wide; positions below are fixed by the
// software view of the block.
package ufd_pkg;
    localparam int CW_ENABLE  = 0;
    localparam int CW_RXCLR   = 1;
    localparam int CW_TXCLR   = 2;
    localparam int CW_DMA     = 3;
    localparam int CW_TRIG_LO = 6;
    localparam int CW_TRIG_HI = 7;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'd0,
        TRIG_FOUR     = 2'd1,
        TRIG_EIGHT    = 2'd2,
        TRIG_FOURTEEN = 2'd3
    } trig_sel_e;

    // Byte count that a trigger code stands for.
    function automatic int unsigned trig_bytes(trig_sel_e sel);
        case (sel)
            TRIG_ONE:   return 1;
            TRIG_FOUR:  return 4;
            TRIG_EIGHT: return 8;
            default:    return 14;
        endcase
    endfunction
endpackage

// File: rtl/ufd_ctrl_reg.sv
// Module: write-only control byte register.
// Holds enable, DMA mode and trigger code; turns the emptying bits and any
// change of enable into one-cycle flush strobes, combinational with the write.
// Assumes the flush strobes are sampled by the queues at the same edge.
module ufd_ctrl_reg
    import ufd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic [7:0] wr_data,
    output logic      fifo_en,
    output logic      dma_mode,
    output trig_sel_e trig_sel,
    output logic      rx_flush,
    output logic      tx_flush
);
    logic      en_q;
    logic      dma_q;
    trig_sel_e trig_q;
    logic      new_en;
    logic      en_change;
    logic      unused_bits;

    assign new_en      = wr_data[CW_ENABLE];
    assign unused_bits = ^wr_data[5:4];

    // Flush strobes: enable change empties both, emptying bits need enable.
    always_comb begin
        en_change = wr_en && (new_en != en_q);
        rx_flush  = en_change || (wr_en && new_en && wr_data[CW_RXCLR]);
        tx_flush  = en_change || (wr_en && new_en && wr_data[CW_TXCLR]);
    end

    // Control state: upper fields captured only by an enabling write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            dma_q  <= 1'b0;
            trig_q <= TRIG_ONE;
        end else if (wr_en) begin
            en_q <= new_en;
            if (new_en) begin
                dma_q  <= wr_data[CW_DMA];
                trig_q <= trig_sel_e'(wr_data[CW_TRIG_HI:CW_TRIG_LO]);
            end
        end
    end

    assign fifo_en  = en_q;
    assign dma_mode = dma_q;
    assign trig_sel = trig_q;

    a_r2_enable_tracks_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (fifo_en == $past(wr_data[CW_ENABLE])));

    a_r3_fields_held_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[CW_ENABLE]) |=> $stable({dma_mode, trig_sel}));
endmodule

// File: rtl/ufd_byte_fifo.sv
// Module: synchronous byte queue with flush, drop-on-full and hold-on-empty.
// A pop and a push in the same cycle on a full queue are both taken.
// The popped word is registered. Assumes DEPTH >= 2.
module ufd_byte_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty,
    output logic              drop
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic              do_push;
    logic              do_pop;

    // Pointer advance with wrap at DEPTH-1 (DEPTH need not be a power of two).
    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    // Accepted strobes: flush and disable block both.
    always_comb begin
        do_pop  = enable && !flush && pop && !empty;
        do_push = enable && !flush && push && (!full || do_pop);
        drop    = enable && !flush && push && !do_push;
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    // Registered read word, held when nothing is popped.
    always_ff @(posedge clk) begin
        if (!rst_n)      pop_data <= '0;
        else if (do_pop) pop_data <= mem[rd_ptr];
    end

    a_r5_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !flush && push && full && !pop) |=> $stable(count));

    a_r4_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

    a_r7_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> $stable(pop_data));
endmodule

// File: rtl/ufd_dma_req.sv
// Module: sticky RX and TX DMA request flops.
// RX raises on level reached or character time-out; TX raises on the first
// not-full cycle after a full one. An acknowledge clears and wins.
// Assumes dma_on already combines enable and DMA mode.
module ufd_dma_req (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_on,
    input  logic rx_level_hit,
    input  logic char_timeout,
    input  logic rx_ack,
    input  logic tx_full,
    input  logic tx_ack,
    output logic rx_req,
    output logic tx_req
);
    logic tx_full_d;
    logic tx_left_full;

    assign tx_left_full = tx_full_d && !tx_full;

    // Previous-cycle TX full, for the falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_full_d <= 1'b0;
        else        tx_full_d <= tx_full;
    end

    // RX request: set by level or time-out, held until acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || !dma_on) rx_req <= 1'b0;
        else if (rx_ack)       rx_req <= 1'b0;
        else                   rx_req <= rx_req || rx_level_hit || char_timeout;
    end

    // TX request: set on leaving full, held until acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || !dma_on) tx_req <= 1'b0;
        else if (tx_ack)       tx_req <= 1'b0;
        else                   tx_req <= tx_req || tx_left_full;
    end

    a_r9_rx_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_req && dma_on && !rx_ack) |=> rx_req);

    a_r9_rx_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ack |=> !rx_req);

    a_r10_tx_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_on && !tx_ack && tx_full_d && !tx_full) |=> tx_req);

    a_r11_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_on |=> (!rx_req && !tx_req));
endmodule

// File: rtl/uart_fifo_dma_ctrl.sv
// Module: UART queue control top. Ties the control register, the two byte
// queues and the request logic together, and keeps the RX overrun flag and
// the trigger level compare. Assumes DEPTH >= 14 so every trigger level can
// be reached.
module uart_fifo_dma_ctrl
    import ufd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [7:0]        cfg_wr_data,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_push_data,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_pop_data,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_push_data,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_pop_data,
    input  logic              char_timeout,
    input  logic              rx_dma_ack,
    input  logic              tx_dma_ack,
    output logic              fifo_en,
    output logic [CNT_W-1:0]  rx_count,
    output logic              rx_empty,
    output logic              rx_full,
    output logic [CNT_W-1:0]  tx_count,
    output logic              tx_empty,
    output logic              tx_full,
    output logic              rx_overrun,
    output logic              rx_level_hit,
    output logic              rx_dma_req,
    output logic              tx_dma_req
);
    logic             dma_mode;
    trig_sel_e        trig_sel;
    logic             rx_flush;
    logic             tx_flush;
    logic             rx_drop;
    logic             tx_drop_unused;
    logic [CNT_W-1:0] trig_thresh;

    ufd_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_data  (cfg_wr_data),
        .fifo_en  (fifo_en),
        .dma_mode (dma_mode),
        .trig_sel (trig_sel),
        .rx_flush (rx_flush),
        .tx_flush (tx_flush)
    );

    ufd_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (fifo_en),
        .flush     (rx_flush),
        .push      (rx_push),
        .push_data (rx_push_data),
        .pop       (rx_pop),
        .pop_data  (rx_pop_data),
        .count     (rx_count),
        .full      (rx_full),
        .empty     (rx_empty),
        .drop      (rx_drop)
    );

    ufd_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (fifo_en),
        .flush     (tx_flush),
        .push      (tx_push),
        .push_data (tx_push_data),
        .pop       (tx_pop),
        .pop_data  (tx_pop_data),
        .count     (tx_count),
        .full      (tx_full),
        .empty     (tx_empty),
        .drop      (tx_drop_unused)
    );

    // Trigger level as a count-wide constant, then the reached compare.
    always_comb begin
        trig_thresh  = CNT_W'(trig_bytes(trig_sel));
        rx_level_hit = (rx_count >= trig_thresh);
    end

    // Sticky overrun: set by a dropped RX byte, cleared by an RX flush.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_flush) rx_overrun <= 1'b0;
        else if (rx_drop)       rx_overrun <= 1'b1;
    end

    ufd_dma_req u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .dma_on       (fifo_en && dma_mode),
        .rx_level_hit (rx_level_hit),
        .char_timeout (char_timeout),
        .rx_ack       (rx_dma_ack),
        .tx_full      (tx_full),
        .tx_ack       (tx_dma_ack),
        .rx_req       (rx_dma_req),
        .tx_req       (tx_dma_req)
    );

    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !rx_flush) |=> rx_overrun);
endmodule

// File: tb/tb_uart_fifo_dma_ctrl.sv
`timescale 1ns/1ps
module tb_uart_fifo_dma_ctrl;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 16;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr_en = 1'b0;
    logic [7:0] cfg_wr_data = '0;
    logic rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
    logic [DATA_W-1:0] rx_push_data = '0, tx_push_data = '0;
    logic char_timeout = 1'b0, rx_dma_ack = 1'b0, tx_dma_ack = 1'b0;
    logic [DATA_W-1:0] rx_pop_data, tx_pop_data;
    logic fifo_en, rx_empty, rx_full, tx_empty, tx_full;
    logic [CNT_W-1:0] rx_count, tx_count;
    logic rx_overrun, rx_level_hit, rx_dma_req, tx_dma_req;

    always #4 clk = ~clk;

    uart_fifo_dma_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop),
        .rx_pop_data(rx_pop_data), .tx_push(tx_push), .tx_push_data(tx_push_data),
        .tx_pop(tx_pop), .tx_pop_data(tx_pop_data), .char_timeout(char_timeout),
        .rx_dma_ack(rx_dma_ack), .tx_dma_ack(tx_dma_ack), .fifo_en(fifo_en),
        .rx_count(rx_count), .rx_empty(rx_empty), .rx_full(rx_full),
        .tx_count(tx_count), .tx_empty(tx_empty), .tx_full(tx_full),
        .rx_overrun(rx_overrun), .rx_level_hit(rx_level_hit),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
    );

    int n_chk = 0;
    int n_err = 0;

    // Reference model state.
    logic [DATA_W-1:0] rxq[$];
    logic [DATA_W-1:0] txq[$];
    bit m_en, m_dma, m_ovr, m_rxreq, m_txreq, m_txprev;
    int m_trig;
    logic [DATA_W-1:0] m_rxout, m_txout;

    function automatic int lvl(int code);
        case (code)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock of the behavioural reference, from pre-edge state and inputs.
    task automatic model_step();
        bit o_en, on, rx_hit, t_full, rxfl, txfl, chg;
        o_en   = m_en;
        on     = m_en && m_dma;
        rx_hit = rxq.size() >= lvl(m_trig);
        t_full = txq.size() == DEPTH;
        if (!rst_n) begin
            rxq.delete(); txq.delete();
            m_en = 0; m_dma = 0; m_trig = 0; m_ovr = 0;
            m_rxreq = 0; m_txreq = 0; m_txprev = 0; m_rxout = '0; m_txout = '0;
            return;
        end
        m_rxreq  = !on ? 1'b0 : rx_dma_ack ? 1'b0 : (m_rxreq || rx_hit || char_timeout);
        m_txreq  = !on ? 1'b0 : tx_dma_ack ? 1'b0 : (m_txreq || (m_txprev && !t_full));
        m_txprev = t_full;
        rxfl = 0; txfl = 0;
        if (cfg_wr_en) begin
            chg  = cfg_wr_data[0] != m_en;
            rxfl = chg || (cfg_wr_data[0] && cfg_wr_data[1]);
            txfl = chg || (cfg_wr_data[0] && cfg_wr_data[2]);
            m_en = cfg_wr_data[0];
            if (cfg_wr_data[0]) begin
                m_dma  = cfg_wr_data[3];
                m_trig = int'(cfg_wr_data[7:6]);
            end
        end
        if (rxfl) begin
            rxq.delete(); m_ovr = 0;
        end else if (o_en) begin
            if (rx_pop && rxq.size() > 0) m_rxout = rxq.pop_front();
            if (rx_push) begin
                if (rxq.size() < DEPTH) rxq.push_back(rx_push_data);
                else m_ovr = 1;
            end
        end
        if (txfl) txq.delete();
        else if (o_en) begin
            if (tx_pop && txq.size() > 0) m_txout = txq.pop_front();
            if (tx_push && txq.size() < DEPTH) txq.push_back(tx_push_data);
        end
    endtask

    task automatic compare_all();
        chk("R2", "fifo_en", int'(fifo_en), int'(m_en));
        chk("R5", "rx_count", int'(rx_count), rxq.size());
        chk("R5", "tx_count", int'(tx_count), txq.size());
        chk("R5", "rx_full", int'(rx_full), int'(rxq.size() == DEPTH));
        chk("R5", "tx_empty", int'(tx_empty), int'(txq.size() == 0));
        chk("R6", "rx_overrun", int'(rx_overrun), int'(m_ovr));
        chk("R7", "rx_pop_data", int'(rx_pop_data), int'(m_rxout));
        chk("R7", "tx_pop_data", int'(tx_pop_data), int'(m_txout));
        chk("R8", "rx_level_hit", int'(rx_level_hit), int'(rxq.size() >= lvl(m_trig)));
        chk("R9", "rx_dma_req", int'(rx_dma_req), int'(m_rxreq));
        chk("R10", "tx_dma_req", int'(tx_dma_req), int'(m_txreq));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr_cfg(input logic [7:0] b);
        cfg_wr_en = 1'b1; cfg_wr_data = b; cyc(); cfg_wr_en = 1'b0;
    endtask

    task automatic rx_in(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            rx_push = 1'b1; rx_push_data = DATA_W'(base + i); cyc();
        end
        rx_push = 1'b0;
    endtask

    task automatic tx_in(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            tx_push = 1'b1; tx_push_data = DATA_W'(base + i); cyc();
        end
        tx_push = 1'b0;
    endtask

    task automatic rx_out(input int n);
        rx_pop = 1'b1;
        for (int i = 0; i < n; i++) cyc();
        rx_pop = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog all: actual=hung expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        repeat (3) cyc();
        // R1: reset state.
        chk("R1", "rx_count", int'(rx_count), 0);
        chk("R1", "fifo_en", int'(fifo_en), 0);
        chk("R1", "requests", int'({rx_dma_req, tx_dma_req}), 0);
        chk("R1", "rx_pop_data", int'(rx_pop_data), 0);
        rst_n = 1'b1;
        cyc();

        // R2: strobes ignored while disabled.
        rx_push = 1'b1; tx_push = 1'b1; rx_push_data = 8'hAA; cyc();
        rx_push = 1'b0; tx_push = 1'b0;
        chk("R2", "disabled push", int'(rx_count) + int'(tx_count), 0);

        wr_cfg(8'h01);
        chk("R2", "enabled", int'(fifo_en), 1);

        // R5/R6: fill RX past full.
        rx_in(DEPTH + 1, 8'h10);
        chk("R5", "rx full count", int'(rx_count), DEPTH);
        chk("R6", "overrun set", int'(rx_overrun), 1);
        // R5: push and pop together on full.
        rx_push = 1'b1; rx_pop = 1'b1; rx_push_data = 8'h77; cyc();
        rx_push = 1'b0; rx_pop = 1'b0;
        chk("R5", "full push+pop count", int'(rx_count), DEPTH);
        chk("R5", "first out", int'(rx_pop_data), 8'h10);
        rx_out(DEPTH);
        chk("R5", "last out", int'(rx_pop_data), 8'h77);
        // R7: pop from empty holds the word.
        rx_out(2);
        chk("R7", "empty pop holds", int'(rx_pop_data), 8'h77);
        chk("R6", "overrun sticky", int'(rx_overrun), 1);
        wr_cfg(8'h03);
        chk("R4", "overrun cleared", int'(rx_overrun), 0);

        // R9: trigger 4 with DMA.
        wr_cfg(8'h49);
        rx_in(3, 8'h20);
        chk("R9", "below level", int'(rx_dma_req), 0);
        rx_in(1, 8'h23);
        chk("R8", "level 4 hit", int'(rx_level_hit), 1);
        cyc();
        chk("R9", "req raised", int'(rx_dma_req), 1);
        rx_dma_ack = 1'b1; cyc(); rx_dma_ack = 1'b0;
        chk("R9", "ack wins", int'(rx_dma_req), 0);
        cyc();
        chk("R9", "re-raised", int'(rx_dma_req), 1);
        rx_dma_ack = 1'b1; wr_cfg(8'h4B); rx_dma_ack = 1'b0;
        cyc();
        chk("R9", "empty no req", int'(rx_dma_req), 0);
        char_timeout = 1'b1; cyc(); char_timeout = 1'b0;
        chk("R9", "time-out req", int'(rx_dma_req), 1);
        cyc();
        chk("R9", "held", int'(rx_dma_req), 1);
        rx_dma_ack = 1'b1; cyc(); rx_dma_ack = 1'b0;

        // R3: bits 5:4 have no effect, trigger stays 4.
        wr_cfg(8'h79);
        rx_in(3, 8'h30);
        chk("R3", "reserved bits no effect", int'(rx_level_hit), 0);
        rx_in(1, 8'h33);
        chk("R3", "level still 4", int'(rx_level_hit), 1);

        // R8: levels 8 and 14 at their boundaries.
        rx_dma_ack = 1'b1; wr_cfg(8'h8B);
        rx_in(7, 8'h40);
        chk("R8", "7 of 8", int'(rx_level_hit), 0);
        rx_in(1, 8'h47);
        chk("R8", "8 of 8", int'(rx_level_hit), 1);
        wr_cfg(8'hCB);
        rx_in(13, 8'h50);
        chk("R8", "13 of 14", int'(rx_level_hit), 0);
        rx_in(1, 8'h5D);
        chk("R8", "14 of 14", int'(rx_level_hit), 1);
        rx_dma_ack = 1'b0;

        // R10: TX full then not full.
        tx_in(DEPTH, 8'h80);
        cyc();
        chk("R10", "full no req", int'(tx_dma_req), 0);
        tx_pop = 1'b1; cyc(); tx_pop = 1'b0;
        cyc();
        chk("R10", "left full req", int'(tx_dma_req), 1);
        cyc();
        chk("R10", "held", int'(tx_dma_req), 1);
        tx_dma_ack = 1'b1; cyc(); tx_dma_ack = 1'b0;
        cyc();
        chk("R10", "ack cleared", int'(tx_dma_req), 0);

        // R11: DMA mode off keeps requests low.
        rx_dma_ack = 1'b1; wr_cfg(8'h01); rx_dma_ack = 1'b0;
        char_timeout = 1'b1; cyc(); cyc(); char_timeout = 1'b0;
        chk("R11", "no rx req", int'(rx_dma_req), 0);

        // R4: self-clearing, TX flush only, flush beats push.
        wr_cfg(8'h03);
        rx_in(2, 8'h60);
        wr_cfg(8'h01);
        chk("R4", "no stored flush", int'(rx_count), 2);
        wr_cfg(8'h05);
        chk("R4", "tx flushed", int'(tx_count), 0);
        chk("R4", "rx untouched", int'(rx_count), 2);
        rx_push = 1'b1; rx_push_data = 8'h99; wr_cfg(8'h03); rx_push = 1'b0;
        chk("R4", "flush beats push", int'(rx_count), 0);

        // R2: disabling empties both queues.
        rx_in(5, 8'h70);
        tx_in(5, 8'h90);
        wr_cfg(8'hC8);
        chk("R2", "disable flush rx", int'(rx_count), 0);
        chk("R2", "disable flush tx", int'(tx_count), 0);
        chk("R2", "disabled", int'(fifo_en), 0);
        wr_cfg(8'h01);
        chk("R3", "enable writes trig code 0", int'(rx_level_hit), 0);
        rx_in(1, 8'hA0);
        chk("R3", "level 1 hit", int'(rx_level_hit), 1);

        repeat (3) cyc();
        finish_run();
    end
endmodule